// File: doc/BRIEF.md
# Commit-Time Value Validation Queue

This block sits between the front end and the retire stage of a core that speculates on instruction results. For each fetched instruction it receives one record: the equality guess, the confidence and table-hit flags, the remembered result that was looked up at fetch, the PC and the identity of the predictor component that made the guess. From the confidence and hit flags it works out whether that remembered result was actually injected into the pipeline, and it stores that flag with the record.

When an instruction retires, the record at the head is checked against the computed result. The block then reports three things. It raises a pipeline flush if an injected value turns out to be wrong. It gives a resolved equality outcome to train the equality predictor. It issues a write so that the last-value table learns the retired result. A squash from the back end discards the youngest records and keeps a given number of the oldest. A flush clears the whole queue.

Top module: `vvq_top`

## Requirements
- R1: After reset the queue is empty: `enq_ready` is 1, `cmt_ready` is 0 and `flush_req`, `train_valid` and `tblwr_valid` are 0.
- R2: Records leave the queue in the order they were accepted. One accept and one retire may happen in the same cycle.
- R3: A record counts as injected only if its equality guess, its high-confidence flag and its table-hit flag are all 1. `flush_req` is 1 in a retire cycle exactly when the head record is injected and its stored value differs from `cmt_result`.
- R4: In every retire cycle `train_valid` is 1 and carries the head record's PC and provider. `train_eq` is 1 exactly when the record hit the table and its stored value equals `cmt_result`. A table miss always trains as inequality.
- R5: In every retire cycle, with or without a flush, `tblwr_valid` is 1, `tblwr_pc` is the head record's PC and `tblwr_value` is `cmt_result`.
- R6: The queue holds DEPTH records (default 32). Once full, `enq_ready` is 0 and an offered record is dropped.
- R7: While the queue is empty, `cmt_valid` has no effect: `cmt_ready`, `train_valid`, `tblwr_valid` and `flush_req` all stay 0.
- R8: After a cycle with `flush_req` the queue is empty. A record offered in that same cycle is dropped.
- R9: A squash keeps the `squash_keep` oldest records that were present before the edge and drops the rest. A retire in the same cycle is still reported and counts as one of the kept records.
- R10: The retire outputs are combinational. They are valid in the same cycle that `cmt_valid` is high with `cmt_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Fetch offers a record |
| enq_ready | output | 1 | Queue not full |
| enq_pred_eq | input | 1 | Equality guess |
| enq_high_conf | input | 1 | Guess has high confidence |
| enq_tbl_hit | input | 1 | Last-value table hit |
| enq_value | input | 64 | Value read from the table |
| enq_pc | input | 32 | Instruction PC |
| enq_provider | input | 4 | Providing predictor component |
| cmt_valid | input | 1 | Retire offers a result |
| cmt_ready | output | 1 | Queue not empty |
| cmt_result | input | 64 | Computed result |
| squash_valid | input | 1 | Drop younger records |
| squash_keep | input | 6 | Number of oldest records to keep |
| flush_req | output | 1 | Injected value was wrong |
| train_valid | output | 1 | Training outcome valid |
| train_eq | output | 1 | Resolved equality |
| train_pc | output | 32 | PC for training |
| train_provider | output | 4 | Provider for training |
| tblwr_valid | output | 1 | Table update valid |
| tblwr_pc | output | 32 | PC for table update |
| tblwr_value | output | 64 | Retired result for table update |

## Verification
Two pairs of functions can land in the same cycle. In the first, a retire that raises a flush coincides with a new fetch record. In the second, a retire coincides with a squash. The bench provokes each pair on purpose by driving both interfaces together. For the flush case, it checks that the retired record is still reported, that the queue is empty on the next cycle, and that the fetch record was dropped. For the squash case, it checks that the retired record is reported and that exactly the kept records are retired afterwards, in order, before the queue reads empty.

// File: rtl/vvq_pkg.sv
package vvq_pkg;
    localparam int VAL_W  = 64;
    localparam int PC_W   = 32;
    localparam int PROV_W = 4;

    typedef struct packed {
        logic [VAL_W-1:0]  value;
        logic [PC_W-1:0]   pc;
        logic [PROV_W-1:0] prov;
        logic              hit;
        logic              used;
    } vvq_entry_t;

    typedef struct packed {
        logic flush;
        logic eq;
    } vvq_verdict_t;

    function automatic logic injected(input logic pred_eq, input logic high_conf,
                                      input logic hit);
        return pred_eq & high_conf & hit;
    endfunction
endpackage

// File: rtl/vvq_fifo.sv
module vvq_fifo
    import vvq_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  vvq_entry_t       push_data,
    input  logic             pop,
    input  logic             clear,
    input  logic             trunc,
    input  logic [CNT_W-1:0] trunc_keep,
    output vvq_entry_t       head_data,
    output logic             empty,
    output logic             full
);
    vvq_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] head, tail;
    logic [CNT_W-1:0] cnt;
    logic             pop_ok, push_ok;
    logic [CNT_W-1:0] pop_n, keep_eff, base;

    function automatic logic [PTR_W-1:0] wrap_add(input logic [PTR_W-1:0] p,
                                                  input logic [CNT_W-1:0] n);
        logic [CNT_W:0] s;
        s = (CNT_W+1)'(p) + (CNT_W+1)'(n);
        if (s >= (CNT_W+1)'(DEPTH)) s = s - (CNT_W+1)'(DEPTH);
        return PTR_W'(s);
    endfunction

    assign empty     = (cnt == '0);
    assign full      = (cnt == CNT_W'(DEPTH));
    assign head_data = mem[head];
    assign pop_ok    = pop && !empty;
    assign push_ok   = push && !full && !clear && !trunc;
    assign pop_n     = CNT_W'(pop_ok);
    assign keep_eff  = (trunc_keep < cnt) ? trunc_keep : cnt;
    assign base      = (keep_eff > pop_n) ? keep_eff : pop_n;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            head <= '0;
            tail <= '0;
            cnt  <= '0;
        end else if (trunc) begin
            head <= wrap_add(head, pop_n);
            tail <= wrap_add(head, base);
            cnt  <= base - pop_n;
        end else begin
            head <= wrap_add(head, pop_n);
            tail <= wrap_add(tail, CNT_W'(push_ok));
            cnt  <= cnt + CNT_W'(push_ok) - pop_n;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[tail] <= push_data;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(DEPTH)); // R6
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (full && !pop && !clear && !trunc) |=> full); // R6
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!clear && !trunc && pop_ok && !push_ok) |=> (cnt == $past(cnt) - 1'b1)); // R2
endmodule

// File: rtl/vvq_judge.sv
module vvq_judge
    import vvq_pkg::*;
(
    input  logic             fire,
    input  vvq_entry_t       rec,
    input  logic [VAL_W-1:0] result,
    output vvq_verdict_t     verdict
);
    logic same;
    assign same          = (rec.value == result);
    assign verdict.eq    = fire && rec.hit && same;
    assign verdict.flush = fire && rec.used && !same;
endmodule

// File: rtl/vvq_top.sv
module vvq_top
    import vvq_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enq_valid,
    output logic              enq_ready,
    input  logic              enq_pred_eq,
    input  logic              enq_high_conf,
    input  logic              enq_tbl_hit,
    input  logic [VAL_W-1:0]  enq_value,
    input  logic [PC_W-1:0]   enq_pc,
    input  logic [PROV_W-1:0] enq_provider,
    input  logic              cmt_valid,
    output logic              cmt_ready,
    input  logic [VAL_W-1:0]  cmt_result,
    input  logic              squash_valid,
    input  logic [CNT_W-1:0]  squash_keep,
    output logic              flush_req,
    output logic              train_valid,
    output logic              train_eq,
    output logic [PC_W-1:0]   train_pc,
    output logic [PROV_W-1:0] train_provider,
    output logic              tblwr_valid,
    output logic [PC_W-1:0]   tblwr_pc,
    output logic [VAL_W-1:0]  tblwr_value
);
    vvq_entry_t   new_rec, head_rec;
    vvq_verdict_t verdict;
    logic         empty, full, fire;

    assign new_rec = '{value: enq_value, pc: enq_pc, prov: enq_provider,
                       hit: enq_tbl_hit,
                       used: injected(enq_pred_eq, enq_high_conf, enq_tbl_hit)};

    vvq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst),
        .push(enq_valid), .push_data(new_rec),
        .pop(fire), .clear(verdict.flush),
        .trunc(squash_valid), .trunc_keep(squash_keep),
        .head_data(head_rec), .empty(empty), .full(full)
    );

    vvq_judge u_judge (
        .fire(fire), .rec(head_rec), .result(cmt_result), .verdict(verdict)
    );

    assign enq_ready      = !full;
    assign cmt_ready      = !empty;
    assign fire           = cmt_valid && !empty;
    assign flush_req      = verdict.flush;
    assign train_valid    = fire;
    assign train_eq       = verdict.eq;
    assign train_pc       = head_rec.pc;
    assign train_provider = head_rec.prov;
    assign tblwr_valid    = fire;
    assign tblwr_pc       = head_rec.pc;
    assign tblwr_value    = cmt_result;

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush_req |=> !cmt_ready); // R8
    AST_FLUSH_IS_MISMATCH: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> (train_valid && !train_eq)); // R3
    AST_QUIET_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !cmt_ready |-> (!train_valid && !tblwr_valid && !flush_req)); // R7
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (!enq_ready && !cmt_valid && !squash_valid) |=> !enq_ready); // R6
endmodule

// File: tb/vvq_top_tb.sv
`timescale 1ns/1ps
module vvq_top_tb;
    import vvq_pkg::*;
    localparam int DEPTH = 32;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct {
        logic [VAL_W-1:0]  value;
        logic [PC_W-1:0]   pc;
        logic [PROV_W-1:0] prov;
        bit                hit;
        bit                used;
    } item_t;

    logic clk = 0, rst = 1;
    logic enq_valid = 0, enq_pred_eq = 0, enq_high_conf = 0, enq_tbl_hit = 0;
    logic [VAL_W-1:0] enq_value = '0, cmt_result = '0, tblwr_value;
    logic [PC_W-1:0] enq_pc = '0, train_pc, tblwr_pc;
    logic [PROV_W-1:0] enq_provider = '0, train_provider;
    logic cmt_valid = 0, squash_valid = 0;
    logic [CNT_W-1:0] squash_keep = '0;
    logic enq_ready, cmt_ready, flush_req, train_valid, train_eq, tblwr_valid;

    int checks = 0, fails = 0;
    item_t exp_q[$];
    logic [VAL_W-1:0] res_q[$];

    always #2 clk = ~clk;

    vvq_top #(.DEPTH(DEPTH)) u_dut (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic set_enq(input bit peq, input bit hc, input bit hit,
                           input logic [63:0] v, input logic [31:0] pc,
                           input logic [3:0] prov);
        item_t it;
        enq_valid = 1; enq_pred_eq = peq; enq_high_conf = hc; enq_tbl_hit = hit;
        enq_value = v; enq_pc = pc; enq_provider = prov;
        it.value = v; it.pc = pc; it.prov = prov; it.hit = hit;
        it.used = peq && hc && hit;
        if (enq_ready && !squash_valid) exp_q.push_back(it);
    endtask

    task automatic set_cmt(input logic [63:0] r);
        cmt_valid = 1; cmt_result = r;
        if (exp_q.size() > 0) res_q.push_back(r);
    endtask

    task automatic tick();
        @(posedge clk); #1;
        enq_valid = 0; cmt_valid = 0; squash_valid = 0;
    endtask

    // monitor: pop expected record and result as the design retires
    always @(negedge clk) begin
        if (!rst && train_valid) begin
            if (exp_q.size() == 0 || res_q.size() == 0) begin
                check(0, "R2", "unexpected retire", 1, 0);
            end else begin
                item_t it;
                logic [63:0] r;
                bit e_eq, e_fl;
                it = exp_q.pop_front();
                r = res_q.pop_front();
                e_eq = it.hit && (it.value == r);
                e_fl = it.used && (it.value != r);
                check(train_eq == e_eq, "R4", "train_eq", 64'(train_eq), 64'(e_eq));
                check(flush_req == e_fl, "R3", "flush_req", 64'(flush_req), 64'(e_fl));
                check(train_pc == it.pc && train_provider == it.prov, "R2 R4",
                      "train pc", 64'(train_pc), 64'(it.pc));
                check(tblwr_valid && tblwr_pc == it.pc && tblwr_value == r, "R5",
                      "table write", tblwr_value, r);
                if (e_fl) exp_q.delete();
            end
        end else if (!rst && flush_req) begin
            check(0, "R3", "flush without retire", 1, 0);
        end
    end

    task automatic do_squash(input int keep, input bit with_cmt, input logic [63:0] r);
        int n, deq, ke, tgt;
        n = exp_q.size();
        squash_valid = 1; squash_keep = CNT_W'(keep);
        if (with_cmt) set_cmt(r);
        deq = (with_cmt && n > 0) ? 1 : 0;
        tick();
        ke = (keep < n) ? keep : n;
        tgt = ((ke > deq) ? ke : deq) - deq;
        while (exp_q.size() > tgt) void'(exp_q.pop_back());
    endtask

    initial begin
        #(200000 * 4);
        fails++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1 reset state
        check(enq_ready && !cmt_ready && !flush_req && !train_valid && !tblwr_valid,
              "R1", "reset state", {62'b0, enq_ready, cmt_ready}, 64'h2);

        // R2 R3 R4 R5 R10: mixed record kinds, retire alongside accept
        set_enq(1, 1, 1, 64'h100, 32'h10, 4'd1); tick();
        set_enq(1, 0, 1, 64'h200, 32'h20, 4'd2); set_cmt(64'h100); tick();
        set_enq(1, 1, 0, 64'h300, 32'h30, 4'd3); set_cmt(64'h201); tick();
        set_enq(0, 1, 1, 64'h400, 32'h40, 4'd4); set_cmt(64'h300); tick();
        set_cmt(64'h400); tick();
        @(negedge clk);
        check(!cmt_ready, "R2", "drained", 64'(cmt_ready), 0);

        // R7 retire on empty queue is ignored
        cmt_valid = 1; cmt_result = 64'h5;
        @(negedge clk);
        check(!train_valid && !tblwr_valid && !flush_req && !cmt_ready, "R7",
              "empty retire", 64'(train_valid), 0);
        tick();

        // R6 fill to depth
        for (int i = 0; i < DEPTH; i++) begin
            set_enq(1, 1, 1, 64'(i * 7), 32'(i + 1000), 4'(i)); tick();
        end
        @(negedge clk);
        check(!enq_ready, "R6", "full ready", 64'(enq_ready), 0);
        set_enq(1, 1, 1, 64'hDEAD, 32'hBAD, 4'd9); tick();
        for (int i = 0; i < DEPTH; i++) begin
            set_cmt(64'(i * 7)); tick();
        end
        @(negedge clk);
        check(!cmt_ready && enq_ready, "R6", "extra record dropped", 64'(cmt_ready), 0);

        // R8 flush with concurrent accept
        set_enq(1, 1, 1, 64'h10, 32'h500, 4'd5); tick();
        set_enq(0, 0, 1, 64'h11, 32'h501, 4'd6); tick();
        set_enq(1, 1, 1, 64'h12, 32'h502, 4'd7); set_cmt(64'h99); tick();
        @(negedge clk);
        check(!cmt_ready, "R8", "flush empties", 64'(cmt_ready), 0);
        set_enq(1, 1, 1, 64'h77, 32'h600, 4'd8); tick();
        set_cmt(64'h77); tick();

        // R9 squash with concurrent retire
        for (int i = 0; i < 5; i++) begin
            set_enq(0, 0, 1, 64'(i + 50), 32'(i + 700), 4'(i)); tick();
        end
        do_squash(3, 1, 64'd50);
        set_cmt(64'd51); tick();
        set_cmt(64'd99); tick();
        @(negedge clk);
        check(!cmt_ready, "R9", "squash keep 3", 64'(cmt_ready), 0);

        // R9 squash without retire
        for (int i = 0; i < 3; i++) begin
            set_enq(1, 1, 1, 64'(i + 80), 32'(i + 800), 4'(i)); tick();
        end
        do_squash(1, 0, 64'd0);
        set_cmt(64'd80); tick();
        @(negedge clk);
        check(!cmt_ready, "R9", "squash keep 1", 64'(cmt_ready), 0);

        check(res_q.size() == 0 && exp_q.size() == 0, "R2", "scoreboard empty",
              64'(res_q.size()), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule